// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block decides, for each of the two ALU operands of the instruction now in the execute stage of a five-stage in-order integer pipeline, where that operand's value should come from. There are three possible sources:

- the value read from the register file;
- the result waiting in the execute/memory pipeline register;
- the result waiting in the memory/writeback pipeline register.

The decision compares the two source register numbers of the executing instruction with the destination numbers and write flags of the two older instructions that sit further down the pipeline.

The selection is purely combinational. Each operand gets a 2-bit select code, and a thin data multiplexer in the same wrapper turns that code into the operand value. When both older instructions target the same register, the nearer one (execute/memory) wins, because it holds the newest value. Register zero is never forwarded, and neither is an instruction that does not write a register.

Top module: `fwd_unit`

## Requirements
- R1: Operand A's select depends only on `ex_src_a`, and operand B's select depends only on `ex_src_b`. Each is compared with the same destination fields.
- R2: A select is 2'b10 (execute/memory result) when the memory stage writes, its destination is nonzero, and its destination equals that operand's source register.
- R3: A select is 2'b01 (memory/writeback result) when the writeback stage writes to a nonzero destination equal to the operand's source register, and the R2 condition is false for that operand.
- R4: A select is 2'b00 (register file) when neither stage satisfies its condition. The code 2'b11 never appears.
- R5: A stage whose write flag is low is never forwarded from, whatever its destination number.
- R6: A destination of register 0 is never forwarded from, even when its write flag is high and the source register is also 0.
- R7: When both stages match the same operand, the select is 2'b10, so the most recent producer wins.
- R8: The two selects are independent. Both operands may pick the same stage, or different stages, in the same cycle.
- R9: `opnd_a` and `opnd_b` carry the register file value, the execute/memory result or the memory/writeback result, as chosen by code 00, 10 or 01 respectively.
- R10: Selects and operand values hold no state. They follow an input change within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | AW (5) | Source register number for operand A of the executing instruction |
| ex_src_b | input | AW (5) | Source register number for operand B of the executing instruction |
| mem_dst | input | AW (5) | Destination register number held in the execute/memory register |
| mem_wen | input | 1 | Register-write flag held in the execute/memory register |
| wb_dst | input | AW (5) | Destination register number held in the memory/writeback register |
| wb_wen | input | 1 | Register-write flag held in the memory/writeback register |
| rf_a | input | DW (32) | Register file read value for operand A |
| rf_b | input | DW (32) | Register file read value for operand B |
| mem_result | input | DW (32) | Result value in the execute/memory register |
| wb_result | input | DW (32) | Result value in the memory/writeback register |
| sel_a | output | 2 | Source select for operand A |
| sel_b | output | 2 | Source select for operand B |
| opnd_a | output | DW (32) | Forwarded value of operand A |
| opnd_b | output | DW (32) | Forwarded value of operand B |

## Verification
The bench targets the double hazard, where both stages write the register an operand reads. If the priority were reversed, the operand would silently receive a stale, older result. It also drives register 0 as destination and source with the write flag high, which would send a spurious forwarded value into a read of the hard-wired zero register. Vectors with a matching destination but a low write flag catch a unit that ignores the flag and forwards from stores or branches. Cases where A and B pick different stages catch crossed source fields, and random traffic is compared against an independently written priority function.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  // Operand source codes; the encodings are seen by the datapath muxes.
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_WBACK   = 2'b01,
    SRC_EXMEM   = 2'b10
  } fwd_src_e;

  localparam int unsigned NUM_OPND = 2;

endpackage

// File: rtl/fwd_match.sv
// One stage-versus-operand comparison: does this stage own the newest copy
// of the register the operand reads?
module fwd_match #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic          wen,
  output logic          hit
);

  function automatic logic producer_matches(input logic [AW-1:0] s,
                                            input logic [AW-1:0] d,
                                            input logic          w);
    logic dst_live;
    dst_live = w && (d != '0);
    return dst_live && (d == s);
  endfunction

  assign hit = producer_matches(src, dst, wen);

endmodule

// File: rtl/fwd_prio.sv
// Priority resolution: the execute/memory producer is newer and wins.
module fwd_prio
  import fwd_pkg::*;
(
  input  logic     near_hit,
  input  logic     far_hit,
  output fwd_src_e sel,
  output logic     far_shadowed
);

  assign far_shadowed = near_hit && far_hit;

  always_comb begin
    if (near_hit)      sel = SRC_EXMEM;
    else if (far_hit)  sel = SRC_WBACK;
    else               sel = SRC_REGFILE;
  end

endmodule

// File: rtl/fwd_mux.sv
// Operand data multiplexer driven by a select code.
module fwd_mux
  import fwd_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  fwd_src_e      sel,
  input  logic [DW-1:0] rf_val,
  input  logic [DW-1:0] exmem_val,
  input  logic [DW-1:0] wback_val,
  output logic [DW-1:0] out_val
);

  always_comb begin
    unique case (sel)
      SRC_EXMEM: out_val = exmem_val;
      SRC_WBACK: out_val = wback_val;
      default:   out_val = rf_val;
    endcase
  end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 32
) (
  input  logic [AW-1:0] ex_src_a,
  input  logic [AW-1:0] ex_src_b,
  input  logic [AW-1:0] mem_dst,
  input  logic          mem_wen,
  input  logic [AW-1:0] wb_dst,
  input  logic          wb_wen,
  input  logic [DW-1:0] rf_a,
  input  logic [DW-1:0] rf_b,
  input  logic [DW-1:0] mem_result,
  input  logic [DW-1:0] wb_result,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic [DW-1:0] opnd_a,
  output logic [DW-1:0] opnd_b
);

  logic [NUM_OPND-1:0][AW-1:0] src_vec;
  logic [NUM_OPND-1:0][DW-1:0] rf_vec;
  logic [NUM_OPND-1:0][DW-1:0] opnd_vec;
  fwd_src_e                    sel_vec [NUM_OPND];

  // Named internal events, visible to the bound checker.
  logic [NUM_OPND-1:0] near_hit;
  logic [NUM_OPND-1:0] far_hit;
  logic [NUM_OPND-1:0] far_shadowed;

  assign src_vec = {ex_src_b, ex_src_a};
  assign rf_vec  = {rf_b, rf_a};

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    fwd_match #(.AW(AW)) u_near (
      .src (src_vec[g]),
      .dst (mem_dst),
      .wen (mem_wen),
      .hit (near_hit[g])
    );

    fwd_match #(.AW(AW)) u_far (
      .src (src_vec[g]),
      .dst (wb_dst),
      .wen (wb_wen),
      .hit (far_hit[g])
    );

    fwd_prio u_prio (
      .near_hit     (near_hit[g]),
      .far_hit      (far_hit[g]),
      .sel          (sel_vec[g]),
      .far_shadowed (far_shadowed[g])
    );

    fwd_mux #(.DW(DW)) u_mux (
      .sel       (sel_vec[g]),
      .rf_val    (rf_vec[g]),
      .exmem_val (mem_result),
      .wback_val (wb_result),
      .out_val   (opnd_vec[g])
    );
  end

  assign sel_a  = sel_vec[0];
  assign sel_b  = sel_vec[1];
  assign opnd_a = opnd_vec[0];
  assign opnd_b = opnd_vec[1];

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 32
) (
  input logic [AW-1:0] ex_src_a,
  input logic [AW-1:0] ex_src_b,
  input logic [AW-1:0] mem_dst,
  input logic          mem_wen,
  input logic [AW-1:0] wb_dst,
  input logic          wb_wen,
  input logic [DW-1:0] rf_a,
  input logic [DW-1:0] mem_result,
  input logic [DW-1:0] wb_result,
  input logic [1:0]    sel_a,
  input logic [1:0]    sel_b,
  input logic [DW-1:0] opnd_a,
  input logic [1:0]    far_shadowed
);

  always_comb begin
    // R4: the unused code never leaves the unit
    a_r4_no_code11: assert (sel_a != 2'b11 && sel_b != 2'b11)
      else $error("select code 11 observed");
    // R5: forwarding from the near stage needs its write flag
    a_r5_near_needs_wen: assert (sel_a != 2'b10 || mem_wen)
      else $error("near forward without write flag");
    // R6: register zero is never a forwarding source
    a_r6_zero_never: assert (!(sel_a != 2'b00 && ex_src_a == '0) &&
                             !(sel_b != 2'b00 && ex_src_b == '0))
      else $error("register zero forwarded");
    // R2: a near select implies the destination actually matches
    a_r2_near_match: assert (sel_b != 2'b10 || mem_dst == ex_src_b)
      else $error("near select without matching destination");
    // R3: a far select implies the far stage writes the operand register
    a_r3_far_match: assert (sel_a != 2'b01 || (wb_wen && wb_dst == ex_src_a))
      else $error("far select without matching producer");
    // R7: when the far match is shadowed, the near stage must be chosen
    a_r7_nearest_wins: assert (!far_shadowed[0] || sel_a == 2'b10)
      else $error("older producer chosen over newer one");
    // R9: operand data follows its select
    a_r9_data_follows: assert ((sel_a == 2'b10) ? (opnd_a == mem_result) :
                               (sel_a == 2'b01) ? (opnd_a == wb_result) :
                                                  (opnd_a == rf_a))
      else $error("operand A data disagrees with its select");
  end

endmodule

bind fwd_unit fwd_unit_chk #(.AW(AW), .DW(DW)) u_chk (
  .ex_src_a     (ex_src_a),
  .ex_src_b     (ex_src_b),
  .mem_dst      (mem_dst),
  .mem_wen      (mem_wen),
  .wb_dst       (wb_dst),
  .wb_wen       (wb_wen),
  .rf_a         (rf_a),
  .mem_result   (mem_result),
  .wb_result    (wb_result),
  .sel_a        (sel_a),
  .sel_b        (sel_b),
  .opnd_a       (opnd_a),
  .far_shadowed (far_shadowed)
);

// File: tb/tb_fwd_unit.sv
module tb_fwd_unit;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam int NVEC = 10;
  localparam int NRAND = 400;
  localparam int WATCHDOG = 5000;

  // Vector layout: src_a, src_b, mem_dst, mem_wen, wb_dst, wb_wen, exp_a, exp_b
  localparam logic [25:0] VEC [NVEC] = '{
    {5'd3,  5'd4,  5'd3,  1'b1, 5'd4,  1'b1, 2'b10, 2'b01}, // R2 R3 R8
    {5'd3,  5'd3,  5'd3,  1'b1, 5'd3,  1'b1, 2'b10, 2'b10}, // R7 double hazard
    {5'd3,  5'd3,  5'd3,  1'b0, 5'd3,  1'b1, 2'b01, 2'b01}, // R5 near flag low
    {5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00}, // R6 zero register
    {5'd7,  5'd9,  5'd1,  1'b1, 5'd2,  1'b1, 2'b00, 2'b00}, // R4 no match
    {5'd5,  5'd6,  5'd6,  1'b1, 5'd5,  1'b1, 2'b01, 2'b10}, // R1 crossed fields
    {5'd8,  5'd8,  5'd8,  1'b0, 5'd8,  1'b0, 2'b00, 2'b00}, // R5 both flags low
    {5'd31, 5'd31, 5'd31, 1'b1, 5'd0,  1'b1, 2'b10, 2'b10}, // R2 top register
    {5'd0,  5'd12, 5'd0,  1'b1, 5'd12, 1'b1, 2'b00, 2'b01}, // R6 R3
    {5'd4,  5'd4,  5'd4,  1'b1, 5'd9,  1'b1, 2'b10, 2'b10}  // R8 same stage
  };

  logic clk = 1'b0;
  logic [AW-1:0] ex_src_a = '0, ex_src_b = '0, mem_dst = '0, wb_dst = '0;
  logic mem_wen = 1'b0, wb_wen = 1'b0;
  logic [DW-1:0] rf_a = '0, rf_b = '0, mem_result = '0, wb_result = '0;
  logic [1:0] sel_a, sel_b;
  logic [DW-1:0] opnd_a, opnd_b;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fwd_unit #(.AW(AW), .DW(DW)) dut (
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
    .mem_dst(mem_dst), .mem_wen(mem_wen),
    .wb_dst(wb_dst), .wb_wen(wb_wen),
    .rf_a(rf_a), .rf_b(rf_b),
    .mem_result(mem_result), .wb_result(wb_result),
    .sel_a(sel_a), .sel_b(sel_b),
    .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  // Independent reference: walk the producers from newest to oldest.
  function automatic logic [1:0] ref_sel(input logic [AW-1:0] src,
                                         input logic [AW-1:0] md, input logic mw,
                                         input logic [AW-1:0] wd, input logic ww);
    if (src == '0) return 2'b00;
    if (mw && md == src) return 2'b10;
    if (ww && wd == src) return 2'b01;
    return 2'b00;
  endfunction

  task automatic check2(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic checkd(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [AW-1:0] sa, input logic [AW-1:0] sb,
                       input logic [AW-1:0] md, input logic mw,
                       input logic [AW-1:0] wd, input logic ww);
    ex_src_a = sa; ex_src_b = sb;
    mem_dst = md; mem_wen = mw; wb_dst = wd; wb_wen = ww;
  endtask

  initial begin
    rf_a = 32'hAAAA_0001; rf_b = 32'hBBBB_0002;
    mem_result = 32'hCCCC_0003; wb_result = 32'hDDDD_0004;
    @(negedge clk);
    // R4: idle inputs select the register file
    check2("R4 idle sel_a", sel_a, 2'b00);
    check2("R4 idle sel_b", sel_b, 2'b00);

    for (int i = 0; i < NVEC; i++) begin
      @(posedge clk);
      drive(VEC[i][25:21], VEC[i][20:16], VEC[i][15:11], VEC[i][10],
            VEC[i][9:5], VEC[i][4]);
      @(negedge clk);
      check2($sformatf("R1-vector %0d sel_a", i), sel_a, VEC[i][3:2]);
      check2($sformatf("R1-vector %0d sel_b", i), sel_b, VEC[i][1:0]);
    end

    // R9: data path follows each code
    @(posedge clk); drive(5'd3, 5'd4, 5'd3, 1'b1, 5'd4, 1'b1);
    @(negedge clk);
    checkd("R9 opnd_a from exmem", opnd_a, mem_result);
    checkd("R9 opnd_b from wback", opnd_b, wb_result);
    @(posedge clk); drive(5'd3, 5'd4, 5'd9, 1'b1, 5'd9, 1'b1);
    @(negedge clk);
    checkd("R9 opnd_a from regfile", opnd_a, rf_a);
    checkd("R9 opnd_b from regfile", opnd_b, rf_b);

    // R10: a change with no clock edge is reflected immediately
    @(negedge clk);
    #1 drive(5'd6, 5'd6, 5'd6, 1'b1, 5'd0, 1'b0);
    #1 check2("R10 same-cycle sel_a", sel_a, 2'b10);
    checkd("R10 same-cycle opnd_b", opnd_b, mem_result);
    #1 mem_wen = 1'b0;
    #1 check2("R10 flag drop sel_b", sel_b, 2'b00);

    // R6: zero destination with flags high, nonzero sources
    @(posedge clk); drive(5'd1, 5'd2, 5'd0, 1'b1, 5'd0, 1'b1);
    @(negedge clk);
    check2("R6 zero dst sel_a", sel_a, 2'b00);
    checkd("R6 zero dst opnd_b", opnd_b, rf_b);

    // Random traffic against the reference; small register range for hits.
    for (int i = 0; i < NRAND; i++) begin
      logic [AW-1:0] sa, sb, md, wd;
      @(posedge clk);
      sa = AW'($urandom_range(0, 3)); sb = AW'($urandom_range(0, 3));
      md = AW'($urandom_range(0, 3)); wd = AW'($urandom_range(0, 3));
      drive(sa, sb, md, 1'($urandom), wd, 1'($urandom));
      rf_a = $urandom; rf_b = $urandom; mem_result = $urandom; wb_result = $urandom;
      @(negedge clk);
      check2("R7 random sel_a", sel_a, ref_sel(sa, md, mem_wen, wd, wb_wen));
      check2("R8 random sel_b", sel_b, ref_sel(sb, md, mem_wen, wd, wb_wen));
    end

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule